// File: doc/BRIEF.md
# Cache Line Metadata Register

This block holds the bookkeeping of a single cache line: a status byte of independent flags, the line tag, the requestor and task identifiers that own the fill, a saturating reference count, the time at which the line was filled and the time from which its data may be used. A cache instantiates one per line and drives it through a single command port. Each command carries its own operands. Current time comes from a free-running counter on `now_i`.

The block decodes the flags into two permissions and into a coherence-state code. It also judges each command as it arrives. A command that does not fit the current state raises `err_o` in the same cycle and changes no state. Legal commands take effect at the next rising clock edge.

Top module: `line_meta_reg`

## Requirements
- R1: After reset, status_o is 0, tag_o is 0, req_id_o and task_id_o are all ones (the invalid-requestor and unknown-task codes), ref_cnt_o and insert_time_o are 0, ready_time_o is all ones (the "never" sentinel) and coh_o is 0.
- R2: Status bit positions are: valid 0, write permission 1, read permission 2, dirty 3, prefetched-unaccessed 5, secure 6, compressed 7, and bit 4 is always 0. writable_o is 1 only when bits 1 and 0 are both set. readable_o is 1 only when bits 2 and 0 are both set, so a valid line without read permission is not readable.
- R3: coh_o decodes {writable_o, dirty, valid}: 111 gives 4 (M), 011 gives 3 (O), 101 gives 2 (E), 001 gives 1 (S), 000 gives 0 (I), and any other value gives 5 (transient).
- R4: Invalidate is always legal. It clears every status bit, the tag, the reference count and the insertion time. It sets task_id_o and req_id_o to all ones and ready_time_o to all ones.
- R5: Insert on an invalid line loads the tag, secure, compressed, write permission, read permission, prefetched, requestor and task operands. It sets the reference count to 1, records now_i as the insertion time, sets ready_time_o to all ones and sets the valid bit.
- R6: Set-ready loads cmd_time_i into ready_time_o. It is legal only on a valid line with cmd_time_i not less than insert_time_o.
- R7: Query-ready changes no state. It is illegal when the line is invalid or when ready_time_o holds the all-ones sentinel.
- R8: Touch on a valid line increments the reference count, saturating at all ones, and clears the prefetched bit.
- R9: Set-dirty sets bit 3 and mark-prefetched sets bit 5. Each is legal only on a valid line.
- R10: Opcodes are 0 nop, 1 insert, 2 invalidate, 3 set-dirty, 4 mark-prefetched, 5 touch, 6 set-ready and 7 query-ready. An illegal command raises err_o combinationally in its own cycle and leaves every output unchanged after the edge. Insert on a valid line is illegal. err_o is 0 whenever cmd_valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command opcode |
| cmd_tag_i | input | TAG_W | Tag operand for insert |
| cmd_secure_i | input | 1 | Secure-space flag for insert |
| cmd_compressed_i | input | 1 | Compressed flag for insert |
| cmd_wperm_i | input | 1 | Write permission for insert |
| cmd_rperm_i | input | 1 | Read permission for insert |
| cmd_prefetch_i | input | 1 | Line was filled by a hardware prefetch (insert) |
| cmd_req_id_i | input | RID_W | Requestor identifier for insert |
| cmd_task_id_i | input | TID_W | Task identifier for insert |
| cmd_time_i | input | TS_W | Time operand for set-ready |
| now_i | input | TS_W | Current time from a free-running counter |
| err_o | output | 1 | Current command is illegal |
| status_o | output | 8 | Status flag byte |
| writable_o | output | 1 | Line may be written |
| readable_o | output | 1 | Line may be read |
| coh_o | output | 3 | Coherence-state code |
| tag_o | output | TAG_W | Stored tag |
| req_id_o | output | RID_W | Stored requestor identifier |
| task_id_o | output | TID_W | Stored task identifier |
| ref_cnt_o | output | REF_W | Reference count |
| insert_time_o | output | TS_W | Time of last insert |
| ready_time_o | output | TS_W | Time from which data may be used |

## Verification
Some properties are checked by the assertions on every cycle:
- an illegal command leaves the state frozen;
- insert and invalidate put the fields into their defined values;
- touch clears the prefetched flag and the count never wraps;
- a stored ready time is never earlier than the insertion time.

Other behaviour shows only in the bench's scenarios. These scenarios cover the full permission and coherence decode for each reachable flag mix and the combinational timing of err_o. They also cover saturation after a long run of touches, and the boundary at which a ready time equal to the insertion time is accepted while one cycle earlier is refused.

// File: rtl/line_meta_pkg.sv
package line_meta_pkg;

  typedef enum logic [2:0] {
    OP_NOP         = 3'd0,
    OP_INSERT      = 3'd1,
    OP_INVAL       = 3'd2,
    OP_DIRTY       = 3'd3,
    OP_PREFETCH    = 3'd4,
    OP_TOUCH       = 3'd5,
    OP_SET_READY   = 3'd6,
    OP_QUERY_READY = 3'd7
  } lm_op_e;

  typedef enum logic [2:0] {
    COH_I = 3'd0,
    COH_S = 3'd1,
    COH_E = 3'd2,
    COH_O = 3'd3,
    COH_M = 3'd4,
    COH_T = 3'd5
  } lm_coh_e;

  localparam int unsigned ST_W     = 8;
  localparam int unsigned B_VALID  = 0;
  localparam int unsigned B_WPERM  = 1;
  localparam int unsigned B_RPERM  = 2;
  localparam int unsigned B_DIRTY  = 3;
  localparam int unsigned B_PF     = 5;
  localparam int unsigned B_SECURE = 6;
  localparam int unsigned B_COMP   = 7;

  // one-hot strobes of an accepted command
  typedef struct packed {
    logic insert;
    logic inval;
    logic dirty;
    logic pf;
    logic touch;
    logic ready;
  } lm_act_t;

endpackage

// File: rtl/lm_cmd_check.sv
module lm_cmd_check
  import line_meta_pkg::*;
(
  input  logic    cmd_valid_i,
  input  lm_op_e  op_i,
  input  logic    line_valid_i,
  input  logic    ready_never_i,
  input  logic    time_early_i,
  output logic    err_o,
  output lm_act_t act_o
);

  logic bad;

  always_comb begin
    bad = 1'b0;
    unique case (op_i)
      OP_NOP:         bad = 1'b0;
      OP_INSERT:      bad = line_valid_i;
      OP_INVAL:       bad = 1'b0;
      OP_DIRTY,
      OP_PREFETCH,
      OP_TOUCH:       bad = !line_valid_i;
      OP_SET_READY:   bad = !line_valid_i || time_early_i;
      OP_QUERY_READY: bad = !line_valid_i || ready_never_i;
      default:        bad = 1'b1;
    endcase
  end

  assign err_o = cmd_valid_i && bad;

  logic go;
  assign go = cmd_valid_i && !bad;

  always_comb begin
    act_o        = '0;
    act_o.insert = go && (op_i == OP_INSERT);
    act_o.inval  = go && (op_i == OP_INVAL);
    act_o.dirty  = go && (op_i == OP_DIRTY);
    act_o.pf     = go && (op_i == OP_PREFETCH);
    act_o.touch  = go && (op_i == OP_TOUCH);
    act_o.ready  = go && (op_i == OP_SET_READY);
  end

  // R10: at most one action, and never alongside an error
  always_comb begin
    p_one_action_r10: assert ($countones(act_o) <= 1 && !(err_o && (act_o != '0)));
  end

endmodule

// File: rtl/lm_status_reg.sv
module lm_status_reg
  import line_meta_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  lm_act_t         act_i,
  input  logic            secure_i,
  input  logic            comp_i,
  input  logic            wperm_i,
  input  logic            rperm_i,
  input  logic            pf_i,
  output logic [ST_W-1:0] status_o,
  output logic            writable_o,
  output logic            readable_o,
  output lm_coh_e         coh_o
);

  logic [ST_W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (act_i.inval) begin
      st_d = '0;
    end else if (act_i.insert) begin
      st_d           = '0;
      st_d[B_VALID]  = 1'b1;
      st_d[B_WPERM]  = wperm_i;
      st_d[B_RPERM]  = rperm_i;
      st_d[B_PF]     = pf_i;
      st_d[B_SECURE] = secure_i;
      st_d[B_COMP]   = comp_i;
    end else begin
      if (act_i.dirty) st_d[B_DIRTY] = 1'b1;
      if (act_i.pf)    st_d[B_PF]    = 1'b1;
      if (act_i.touch) st_d[B_PF]    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign status_o   = st_q;
  assign writable_o = st_q[B_WPERM] && st_q[B_VALID];
  assign readable_o = st_q[B_RPERM] && st_q[B_VALID];

  always_comb begin
    unique case ({writable_o, st_q[B_DIRTY], st_q[B_VALID]})
      3'b111:  coh_o = COH_M;
      3'b011:  coh_o = COH_O;
      3'b101:  coh_o = COH_E;
      3'b001:  coh_o = COH_S;
      3'b000:  coh_o = COH_I;
      default: coh_o = COH_T;
    endcase
  end

  p_touch_clears_pf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.touch |=> !status_o[B_PF] && status_o[B_VALID]);

  p_dirty_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.dirty |=> status_o[B_DIRTY]);

  p_bit4_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[4]);

endmodule

// File: rtl/lm_stamp_reg.sv
module lm_stamp_reg
  import line_meta_pkg::*;
#(
  parameter int unsigned REF_W = 3,
  parameter int unsigned TS_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lm_act_t          act_i,
  input  logic [TS_W-1:0]  now_i,
  input  logic [TS_W-1:0]  ready_i,
  output logic [REF_W-1:0] ref_cnt_o,
  output logic [TS_W-1:0]  ins_time_o,
  output logic [TS_W-1:0]  rdy_time_o
);

  localparam logic [REF_W-1:0] REF_MAX = '1;
  localparam logic [TS_W-1:0]  NEVER   = '1;

  logic [REF_W-1:0] ref_q;
  logic [TS_W-1:0]  ins_q, rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      ins_q <= '0;
      rdy_q <= NEVER;
    end else if (act_i.inval) begin
      ref_q <= '0;
      ins_q <= '0;
      rdy_q <= NEVER;
    end else if (act_i.insert) begin
      ref_q <= REF_W'(1);
      ins_q <= now_i;
      rdy_q <= NEVER;
    end else begin
      if (act_i.touch && ref_q != REF_MAX) ref_q <= ref_q + REF_W'(1);
      if (act_i.ready) rdy_q <= ready_i;
    end
  end

  assign ref_cnt_o  = ref_q;
  assign ins_time_o = ins_q;
  assign rdy_time_o = rdy_q;

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i.touch && ref_cnt_o == REF_MAX) |=> ref_cnt_o == REF_MAX);

  p_touch_counts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i.touch && ref_cnt_o != REF_MAX) |=> ref_cnt_o == $past(ref_cnt_o) + REF_W'(1));

  p_ready_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_time_o != NEVER) |-> rdy_time_o >= ins_time_o);

endmodule

// File: rtl/line_meta_reg.sv
module line_meta_reg
  import line_meta_pkg::*;
#(
  parameter int unsigned TAG_W = 20,
  parameter int unsigned RID_W = 4,
  parameter int unsigned TID_W = 8,
  parameter int unsigned REF_W = 3,
  parameter int unsigned TS_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [TAG_W-1:0] cmd_tag_i,
  input  logic             cmd_secure_i,
  input  logic             cmd_compressed_i,
  input  logic             cmd_wperm_i,
  input  logic             cmd_rperm_i,
  input  logic             cmd_prefetch_i,
  input  logic [RID_W-1:0] cmd_req_id_i,
  input  logic [TID_W-1:0] cmd_task_id_i,
  input  logic [TS_W-1:0]  cmd_time_i,
  input  logic [TS_W-1:0]  now_i,
  output logic             err_o,
  output logic [7:0]       status_o,
  output logic             writable_o,
  output logic             readable_o,
  output logic [2:0]       coh_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [RID_W-1:0] req_id_o,
  output logic [TID_W-1:0] task_id_o,
  output logic [REF_W-1:0] ref_cnt_o,
  output logic [TS_W-1:0]  insert_time_o,
  output logic [TS_W-1:0]  ready_time_o
);

  localparam logic [RID_W-1:0] RID_INVALID  = '1;
  localparam logic [TID_W-1:0] TID_UNKNOWN  = '1;
  localparam logic [TS_W-1:0]  NEVER        = '1;

  lm_act_t act;
  lm_coh_e coh;

  lm_cmd_check u_check (
    .cmd_valid_i   (cmd_valid_i),
    .op_i          (lm_op_e'(cmd_op_i)),
    .line_valid_i  (status_o[B_VALID]),
    .ready_never_i (ready_time_o == NEVER),
    .time_early_i  (cmd_time_i < insert_time_o),
    .err_o         (err_o),
    .act_o         (act)
  );

  lm_status_reg u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .secure_i   (cmd_secure_i),
    .comp_i     (cmd_compressed_i),
    .wperm_i    (cmd_wperm_i),
    .rperm_i    (cmd_rperm_i),
    .pf_i       (cmd_prefetch_i),
    .status_o   (status_o),
    .writable_o (writable_o),
    .readable_o (readable_o),
    .coh_o      (coh)
  );

  assign coh_o = coh;

  lm_stamp_reg #(.REF_W(REF_W), .TS_W(TS_W)) u_stamp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .now_i      (now_i),
    .ready_i    (cmd_time_i),
    .ref_cnt_o  (ref_cnt_o),
    .ins_time_o (insert_time_o),
    .rdy_time_o (ready_time_o)
  );

  logic [TAG_W-1:0] tag_q;
  logic [RID_W-1:0] rid_q;
  logic [TID_W-1:0] tid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      rid_q <= RID_INVALID;
      tid_q <= TID_UNKNOWN;
    end else if (act.inval) begin
      tag_q <= '0;
      rid_q <= RID_INVALID;
      tid_q <= TID_UNKNOWN;
    end else if (act.insert) begin
      tag_q <= cmd_tag_i;
      rid_q <= cmd_req_id_i;
      tid_q <= cmd_task_id_i;
    end
  end

  assign tag_o     = tag_q;
  assign req_id_o  = rid_q;
  assign task_id_o = tid_q;

  p_illegal_keeps_state_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(status_o) && $stable(tag_o) && $stable(ref_cnt_o) &&
              $stable(ready_time_o) && $stable(insert_time_o) &&
              $stable(req_id_o) && $stable(task_id_o));

  p_insert_loads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !err_o && cmd_op_i == 3'd1) |=>
      status_o[B_VALID] && ref_cnt_o == REF_W'(1) && tag_o == $past(cmd_tag_i) &&
      insert_time_o == $past(now_i) && ready_time_o == NEVER);

  p_invalidate_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd2) |=>
      status_o == '0 && task_id_o == TID_UNKNOWN && req_id_o == RID_INVALID &&
      ref_cnt_o == '0 && ready_time_o == NEVER);

  p_no_err_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> !err_o);

endmodule

// File: tb/line_meta_reg_tb_top.sv
`timescale 1ns/1ps
module line_meta_reg_tb_top;

  localparam int TAG_W = 20, RID_W = 4, TID_W = 8, REF_W = 3, TS_W = 16;
  localparam logic [TS_W-1:0] NEVER = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             c_valid = 0;
  logic [2:0]       c_op = 0;
  logic [TAG_W-1:0] c_tag = 0;
  logic c_sec = 0, c_comp = 0, c_wp = 0, c_rp = 0, c_pf = 0;
  logic [RID_W-1:0] c_rid = 0;
  logic [TID_W-1:0] c_tid = 0;
  logic [TS_W-1:0]  c_time = 0;
  logic [TS_W-1:0]  now = 0;

  logic             err;
  logic [7:0]       status;
  logic             writable, readable;
  logic [2:0]       coh;
  logic [TAG_W-1:0] tag;
  logic [RID_W-1:0] rid;
  logic [TID_W-1:0] tid;
  logic [REF_W-1:0] refc;
  logic [TS_W-1:0]  ins_t, rdy_t;

  line_meta_reg #(.TAG_W(TAG_W), .RID_W(RID_W), .TID_W(TID_W), .REF_W(REF_W), .TS_W(TS_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(c_valid), .cmd_op_i(c_op), .cmd_tag_i(c_tag),
    .cmd_secure_i(c_sec), .cmd_compressed_i(c_comp), .cmd_wperm_i(c_wp), .cmd_rperm_i(c_rp),
    .cmd_prefetch_i(c_pf), .cmd_req_id_i(c_rid), .cmd_task_id_i(c_tid), .cmd_time_i(c_time),
    .now_i(now), .err_o(err), .status_o(status), .writable_o(writable), .readable_o(readable),
    .coh_o(coh), .tag_o(tag), .req_id_o(rid), .task_id_o(tid), .ref_cnt_o(refc),
    .insert_time_o(ins_t), .ready_time_o(rdy_t));

  always @(negedge clk) now <= now + 1'b1;

  // bench model
  logic [7:0]       m_st;
  logic [TAG_W-1:0] m_tag;
  logic [RID_W-1:0] m_rid;
  logic [TID_W-1:0] m_tid;
  logic [REF_W-1:0] m_ref;
  logic [TS_W-1:0]  m_ins, m_rdy;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_coh(input logic [7:0] s);
    logic w;
    w = s[1] & s[0];
    case ({w, s[3], s[0]})
      3'b111: return 3'd4;
      3'b011: return 3'd3;
      3'b101: return 3'd2;
      3'b001: return 3'd1;
      3'b000: return 3'd0;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic exp_err(input logic [2:0] op, input logic [TS_W-1:0] t);
    logic v;
    v = m_st[0];
    case (op)
      3'd1: return v;
      3'd3, 3'd4, 3'd5: return !v;
      3'd6: return !v || (t < m_ins);
      3'd7: return !v || (m_rdy == NEVER);
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    m_st = 0; m_tag = 0; m_rid = '1; m_tid = '1; m_ref = 0; m_ins = 0; m_rdy = NEVER;
  endtask

  task automatic check_all(input string req);
    chk(req, "status", 32'(status), 32'(m_st));
    chk(req, "writable", 32'(writable), 32'(m_st[1] & m_st[0]));
    chk(req, "readable", 32'(readable), 32'(m_st[2] & m_st[0]));
    chk(req, "coh", 32'(coh), 32'(exp_coh(m_st)));
    chk(req, "tag", 32'(tag), 32'(m_tag));
    chk(req, "req_id", 32'(rid), 32'(m_rid));
    chk(req, "task_id", 32'(tid), 32'(m_tid));
    chk(req, "ref_cnt", 32'(refc), 32'(m_ref));
    chk(req, "ins_time", 32'(ins_t), 32'(m_ins));
    chk(req, "rdy_time", 32'(rdy_t), 32'(m_rdy));
  endtask

  task automatic cmd(input string req, input logic [2:0] op, input logic [TAG_W-1:0] tg,
                     input logic [5:0] fl, input logic [RID_W-1:0] r, input logic [TID_W-1:0] k,
                     input logic [TS_W-1:0] t);
    logic e;
    @(negedge clk);
    c_valid = 1; c_op = op; c_tag = tg; c_rid = r; c_tid = k; c_time = t;
    {c_comp, c_sec, c_pf, c_rp, c_wp} = fl[4:0];
    #1;
    e = exp_err(op, t);
    chk(req, "err", 32'(err), 32'(e));
    @(posedge clk);
    if (!e) begin
      case (op)
        3'd1: begin
          m_st = {c_comp, c_sec, c_pf, 1'b0, 1'b0, c_rp, c_wp, 1'b1};
          m_tag = tg; m_rid = r; m_tid = k; m_ref = 1; m_ins = now; m_rdy = NEVER;
        end
        3'd2: model_reset();
        3'd3: m_st[3] = 1'b1;
        3'd4: m_st[5] = 1'b1;
        3'd5: begin m_st[5] = 1'b0; if (m_ref != '1) m_ref = m_ref + 1'b1; end
        3'd6: m_rdy = t;
        default: ;
      endcase
    end
    #1;
    c_valid = 0;
    check_all(req);
  endtask

  initial begin
    #100000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4242);
    model_reset();
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk); #1;
    check_all("R1");
    // idle: no error
    chk("R10", "err idle", 32'(err), 0);
    // illegal on invalid line
    cmd("R10", 3'd5, 0, 0, 0, 0, 0);
    cmd("R6", 3'd6, 0, 0, 0, 0, 16'd5);
    cmd("R7", 3'd7, 0, 0, 0, 0, 0);
    // insert wp only: E, valid not readable
    cmd("R5", 3'd1, 20'hABCDE, 6'b0_1_1_0_01 & 6'b011101, 4'h3, 8'h21, 0);
    cmd("R2", 3'd0, 0, 0, 0, 0, 0);
    cmd("R10", 3'd1, 20'h11111, 0, 0, 0, 0);
    cmd("R3", 3'd3, 0, 0, 0, 0, 0);
    cmd("R7", 3'd7, 0, 0, 0, 0, 0);
    cmd("R6", 3'd6, 0, 0, 0, 0, m_ins - 1'b1);
    cmd("R6", 3'd6, 0, 0, 0, 0, m_ins);
    cmd("R7", 3'd7, 0, 0, 0, 0, 0);
    for (int i = 0; i < 9; i++) cmd("R8", 3'd5, 0, 0, 0, 0, 0);
    cmd("R4", 3'd2, 0, 0, 0, 0, 0);
    // read-only line: S then O after dirty
    cmd("R3", 3'd1, 20'h00042, 6'b000110, 4'h1, 8'h02, 0);
    cmd("R9", 3'd4, 0, 0, 0, 0, 0);
    cmd("R9", 3'd3, 0, 0, 0, 0, 0);
    cmd("R8", 3'd5, 0, 0, 0, 0, 0);
    cmd("R4", 3'd2, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic [TS_W-1:0] t;
      op = 3'($urandom % 8);
      t  = m_ins + TS_W'($urandom % 24) - TS_W'(8);
      cmd("R10", op, TAG_W'($urandom), 6'($urandom), RID_W'($urandom), TID_W'($urandom), t);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule